// File: doc/BRIEF.md
# Sector Hamming Parity Generator and Single-Bit Error Locator

This block builds a Hamming-style parity code over one sector of flash data as bytes stream past it. Each byte is tagged with its position in the sector, and every bit of data is folded into two parity accumulators for each bit of its address: an "odd" accumulator for address bits that are 1 and an "even" accumulator for address bits that are 0. The address is the byte index followed by the bit position within the byte. With the default 512-byte sector that gives 12 address bits and a 24-bit code. The code is presented inverted, which means an erased sector (all bytes 0xFF) produces a code of all ones and matches an erased spare area.

After a sector has been read back, software or a sequencer supplies the stored code and pulses a check request. The block XORs the stored and computed codes and sorts the result into one of four classes. A zero difference means the data is clean. If the odd and even halves of the difference are exact complements, one data bit flipped, and the block reports its byte offset and a one-hot bit mask to XOR into the buffer. If only one bit of the difference is set, the error lies in the stored code and the data is left unchanged. Any other difference is reported as uncorrectable. Applying the fix to buffer memory is left to the caller.

Top module: `sector_hamming_ecc`

## Requirements
- R1: After reset, and in the cycle after a start pulse with no byte, `eccCode` reads all ones (the accumulators are clear). No check result is valid after reset.
- R2: A byte accepted while `inValid` is high is folded in at the next rising edge. For address bit k of the address {byte index, bit position[2:0]}, the odd accumulator takes the XOR of the data bits whose address has bit k = 1, and the even accumulator takes the XOR of those with bit k = 0.
- R3: `eccCode` = bitwise NOT of {odd[ADDR_W-1:0], even[ADDR_W-1:0]}. Its byte 0 sits in bits [7:0] and is the first byte stored. An all-0xFF sector therefore yields all ones.
- R4: A start pulse clears the accumulators and the byte counter. A byte valid in the same cycle becomes byte 0 of the new sector.
- R5: Bytes offered after SECTOR_BYTES bytes have been accepted since the last start have no effect on `eccCode`.
- R6: A check request is answered one cycle later with `resValid` high for one cycle. The difference is stored XOR computed. When the difference is zero, the status is 0 (clean), with `errMask` 0.
- R7: When the low ADDR_W bits of the difference XOR the high ADDR_W bits equal all ones, and the byte offset (the bits above the low 3 of the high half) is below SECTOR_BYTES, the status is 1 (corrected). `errByte` is then that offset and `errMask` is 1 shifted by the high half's bits [2:0].
- R8: A difference with exactly one bit set gives status 2 (code-only error) with `errMask` 0.
- R9: Any other nonzero difference, including a complementary one whose offset is not below SECTOR_BYTES, gives status 3 (uncorrectable) with `errMask` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new sector: clear parity and byte count |
| inValid | input | 1 | `inByte` carries a sector byte this cycle |
| inByte | input | 8 | Sector data byte |
| chkReq | input | 1 | Compare `storedEcc` with the current code |
| storedEcc | input | CODE_W (24) | Code read from the spare area, byte 0 in [7:0] |
| eccCode | output | CODE_W (24) | Inverted computed code, byte 0 in [7:0] |
| resValid | output | 1 | Check result valid (one cycle) |
| status | output | 2 | 0 clean, 1 corrected, 2 code-only, 3 uncorrectable |
| errByte | output | BYTE_W (9) | Byte offset to fix when status is 1 |
| errMask | output | 8 | Bit mask to XOR into that byte when status is 1 |

## Verification
The assertions check the properties that hold on every cycle:
- a result appears exactly one cycle after a request;
- the mask is one-hot only for a corrected status and zero otherwise;
- a reported offset never reaches the sector size;
- the byte count never passes the sector size;
- a bare start leaves the code at all ones.

Only the bench scenarios show that the parity values are right, because that needs an independent model of the code over whole sectors. The scenarios cover:
- flips at the first, last and interior bit positions;
- a single flipped bit in the stored code;
- two flipped data bits;
- overrun bytes that are dropped;
- an out-of-range offset, on a 500-byte instance.

// File: rtl/sector_ecc_pkg.sv
package sector_ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_CODEERR = 2'd2,
    ST_UNCORR  = 2'd3
  } eccStatus_t;

  typedef struct packed {
    logic clrAcc;
    logic foldByte;
    logic chkEn;
  } eccStrobe_t;
endpackage

// File: rtl/sector_ecc_ctrl.sv
module sector_ecc_ctrl
  import sector_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int BYTE_W = $clog2(SECTOR_BYTES),
  localparam int CNT_W = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              chkReq,
  output eccStrobe_t        strobe,
  output logic [BYTE_W-1:0] byteIdx
);
  logic [CNT_W-1:0] count;
  logic             room;

  assign room = (count < CNT_W'(SECTOR_BYTES));

  always_comb begin
    strobe.clrAcc   = start;
    strobe.foldByte = inValid && (start || room);
    strobe.chkEn    = chkReq;
    byteIdx         = start ? '0 : count[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (start) count <= inValid ? CNT_W'(1) : '0;
    else if (inValid && room) count <= count + CNT_W'(1);
  end

  // R5: the byte counter never runs past the sector size
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(SECTOR_BYTES));
  // R4: a start pulse restarts the count
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (count <= CNT_W'(1)));
endmodule

// File: rtl/sector_ecc_dpath.sv
module sector_ecc_dpath
  import sector_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int BYTE_W = $clog2(SECTOR_BYTES),
  localparam int BIT_W = 3,
  localparam int ADDR_W = BYTE_W + BIT_W,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobe,
  input  logic [BYTE_W-1:0] byteIdx,
  input  logic [7:0]        inByte,
  input  logic [CODE_W-1:0] storedEcc,
  output logic [CODE_W-1:0] eccCode,
  output logic              resValid,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] errByte,
  output logic [7:0]        errMask
);
  logic [ADDR_W-1:0] oddAcc, evenAcc;
  logic [ADDR_W-1:0] oddHit, evenHit;
  logic              bytePar;

  assign bytePar = ^inByte;

  // mask of bit positions b within a byte whose bit k is set
  function automatic logic [7:0] posMask(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

  for (genvar k = 0; k < ADDR_W; k++) begin : g_par
    if (k < BIT_W) begin : g_bitpos
      assign oddHit[k]  = ^(inByte & posMask(k));
      assign evenHit[k] = ^(inByte & ~posMask(k));
    end else begin : g_bytepos
      assign oddHit[k]  = byteIdx[k-BIT_W] & bytePar;
      assign evenHit[k] = ~byteIdx[k-BIT_W] & bytePar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddAcc  <= '0;
      evenAcc <= '0;
    end else begin
      if (strobe.clrAcc) begin
        oddAcc  <= strobe.foldByte ? oddHit : '0;
        evenAcc <= strobe.foldByte ? evenHit : '0;
      end else if (strobe.foldByte) begin
        oddAcc  <= oddAcc ^ oddHit;
        evenAcc <= evenAcc ^ evenHit;
      end
    end
  end

  assign eccCode = ~{oddAcc, evenAcc};

  // classification
  logic [CODE_W-1:0] diff;
  logic [ADDR_W-1:0] hiHalf, loHalf;
  logic [BYTE_W-1:0] offs;
  logic              complementary, singleBit;
  eccStatus_t        nextStatus;

  assign diff          = storedEcc ^ eccCode;
  assign hiHalf        = diff[CODE_W-1:ADDR_W];
  assign loHalf        = diff[ADDR_W-1:0];
  assign offs          = hiHalf[ADDR_W-1:BIT_W];
  assign complementary = ((hiHalf ^ loHalf) == '1);
  assign singleBit     = (diff != '0) && ((diff & (diff - CODE_W'(1))) == '0);

  always_comb begin
    if (diff == '0) nextStatus = ST_CLEAN;
    else if (complementary && (32'(offs) < SECTOR_BYTES)) nextStatus = ST_FIXED;
    else if (singleBit) nextStatus = ST_CODEERR;
    else nextStatus = ST_UNCORR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      status   <= ST_CLEAN;
      errByte  <= '0;
      errMask  <= '0;
    end else begin
      resValid <= strobe.chkEn;
      if (strobe.chkEn) begin
        status  <= nextStatus;
        errByte <= (nextStatus == ST_FIXED) ? offs : '0;
        errMask <= (nextStatus == ST_FIXED) ? (8'd1 << hiHalf[BIT_W-1:0]) : 8'd0;
      end
    end
  end

  // R6: a result follows a request by exactly one cycle
  a_r6_result_timing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.chkEn |=> resValid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.chkEn |=> !resValid);
  // R7: a corrected result carries exactly one mask bit and an in-range offset
  a_r7_mask_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && status == ST_FIXED) |-> ($countones(errMask) == 1 &&
                                          32'(errByte) < SECTOR_BYTES));
  // R8 R9: no mask unless a data bit is corrected
  a_r9_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && status != ST_FIXED) |-> (errMask == 8'd0));
  // R1 R4: a start without a byte leaves the code all ones
  a_r1_cleared_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrAcc && !strobe.foldByte) |=> (eccCode == '1));
endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc
  import sector_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int BYTE_W = $clog2(SECTOR_BYTES),
  localparam int ADDR_W = BYTE_W + 3,
  localparam int CODE_W = 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              chkReq,
  input  logic [CODE_W-1:0] storedEcc,
  output logic [CODE_W-1:0] eccCode,
  output logic              resValid,
  output logic [1:0]        status,
  output logic [BYTE_W-1:0] errByte,
  output logic [7:0]        errMask
);
  eccStrobe_t        strobe;
  logic [BYTE_W-1:0] byteIdx;

  sector_ecc_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .chkReq(chkReq), .strobe(strobe), .byteIdx(byteIdx)
  );

  sector_ecc_dpath #(.SECTOR_BYTES(SECTOR_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteIdx(byteIdx),
    .inByte(inByte), .storedEcc(storedEcc), .eccCode(eccCode),
    .resValid(resValid), .status(status), .errByte(errByte),
    .errMask(errMask)
  );
endmodule

// File: tb/sector_hamming_ecc_tb.sv
module sector_hamming_ecc_tb;
  localparam int SB = 512;
  localparam int SB2 = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, inValid = 0, chkReq = 0;
  logic [7:0] inByte = 0;
  logic [23:0] storedEcc = 0;
  logic [23:0] eccCode;
  logic resValid;
  logic [1:0] status;
  logic [8:0] errByte;
  logic [7:0] errMask;

  logic start2 = 0, chk2 = 0;
  logic [23:0] stored2 = 0;
  logic [23:0] ecc2;
  logic resValid2;
  logic [1:0] status2;
  logic [8:0] errByte2;
  logic [7:0] errMask2;

  int checks = 0;
  int errors = 0;
  logic [7:0] sec [0:SB+15];

  always #10 clk = ~clk;

  sector_hamming_ecc #(.SECTOR_BYTES(SB)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .inByte(inByte),
    .chkReq(chkReq), .storedEcc(storedEcc), .eccCode(eccCode),
    .resValid(resValid), .status(status), .errByte(errByte), .errMask(errMask)
  );

  sector_hamming_ecc #(.SECTOR_BYTES(SB2)) u_small (
    .clk(clk), .rstN(rstN), .start(start2), .inValid(1'b0), .inByte(8'h00),
    .chkReq(chk2), .storedEcc(stored2), .eccCode(ecc2),
    .resValid(resValid2), .status(status2), .errByte(errByte2), .errMask(errMask2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // independent model of the code over the first n bytes of sec
  function automatic logic [23:0] refCode(input int n);
    logic [11:0] odd = '0, even = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (sec[i][b]) begin
          logic [11:0] a;
          a = 12'((i << 3) | b);
          odd  ^= a;
          even ^= ~a;
        end
    return ~{odd, even};
  endfunction

  task automatic fillPattern(input int seed);
    int s = seed;
    for (int i = 0; i < SB + 16; i++) begin
      s = s * 1103515245 + 12345;
      sec[i] = 8'(s >>> 16);
    end
  endtask

  task automatic streamSector(input int n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inByte = sec[i];
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic runCheck(input logic [23:0] st);
    storedEcc = st; chkReq = 1'b1;
    @(negedge clk); chkReq = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset code", eccCode, 24'hFFFFFF);
    check("R1 reset resValid", resValid, 0);
  endtask

  task automatic t_erased();
    for (int i = 0; i < SB; i++) sec[i] = 8'hFF;
    streamSector(SB);
    check("R3 erased code", eccCode, 24'hFFFFFF);
    runCheck(24'hFFFFFF);
    check("R6 erased resValid", resValid, 1);
    check("R6 erased status clean", status, 0);
    @(negedge clk);
    check("R6 resValid one cycle", resValid, 0);
  endtask

  task automatic t_pattern(input int seed);
    logic [23:0] exp;
    fillPattern(seed);
    exp = refCode(SB);
    streamSector(SB);
    check("R2 R3 pattern code", eccCode, exp);
    runCheck(exp);
    check("R6 pattern clean", status, 0);
    check("R6 pattern mask", errMask, 0);
  endtask

  task automatic t_flip(input int seed, input int by, input int bi);
    logic [23:0] good;
    fillPattern(seed);
    good = refCode(SB);
    sec[by][bi] = ~sec[by][bi];
    streamSector(SB);
    runCheck(good);
    check("R7 flip status", status, 1);
    check("R7 flip byte", errByte, by);
    check("R7 flip mask", errMask, 32'(8'd1 << bi));
  endtask

  task automatic t_codeErr();
    logic [23:0] good;
    fillPattern(77);
    good = refCode(SB);
    streamSector(SB);
    runCheck(good ^ 24'h000400);
    check("R8 code-only status", status, 2);
    check("R8 code-only mask", errMask, 0);
  endtask

  task automatic t_double();
    logic [23:0] good;
    fillPattern(91);
    good = refCode(SB);
    sec[10][1] = ~sec[10][1];
    sec[300][6] = ~sec[300][6];
    streamSector(SB);
    runCheck(good);
    check("R9 double status", status, 3);
    check("R9 double mask", errMask, 0);
  endtask

  task automatic t_overrun();
    logic [23:0] exp;
    fillPattern(5);
    exp = refCode(SB);
    streamSector(SB + 16);
    check("R5 overrun ignored", eccCode, exp);
  endtask

  task automatic t_startClear();
    fillPattern(8);
    streamSector(40);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R4 start clears", eccCode, 24'hFFFFFF);
    // start with a byte: that byte is byte 0
    sec[0] = 8'h5A;
    inValid = 1'b1; inByte = 8'h5A; start = 1'b1;
    @(negedge clk); start = 1'b0; inValid = 1'b0;
    check("R4 start with byte", eccCode, refCode(1));
  endtask

  task automatic t_bound();
    logic [11:0] a;
    logic [23:0] d;
    a = 12'(505 << 3);
    d = {a, ~a};
    @(negedge clk); start2 = 1'b1;
    @(negedge clk); start2 = 1'b0;
    stored2 = ecc2 ^ d; chk2 = 1'b1;
    @(negedge clk); chk2 = 1'b0;
    check("R9 offset out of range", status2, 3);
    check("R9 offset out of range mask", errMask2, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_pattern(1);
    t_pattern(1234);
    t_flip(3, 0, 0);
    t_flip(4, 511, 7);
    t_flip(6, 200, 3);
    t_codeErr();
    t_double();
    t_overrun();
    t_startClear();
    t_bound();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule